// File: doc/BRIEF.md
# SIMT Branch Divergence Mask Unit

This unit holds the per-lane execution mask of a SIMT core whose lanes share one instruction stream. When the decoder meets a data-dependent branch, every lane supplies its own condition bit. The unit narrows the mask to the lanes whose condition holds, and those lanes run the taken path. At the else strobe it switches to the lanes that were active before the branch but whose condition was false. At the endif strobe it restores the mask that was in force before the branch. Neither path is skipped for the whole core. Instead, register-file writes are suppressed for every lane that is off the current path, while the ALUs may keep computing.

Branches may nest. A small stack saves, for each open level, the mask before the branch and the mask for the alternative path. The unit flags a path that has no active lanes, so the sequencer may jump over it. It raises a sticky error when a branch opens on a full stack.

Top module: `simt_div_mask_unit`

## Requirements
- R1: After reset, active_o has all lanes set, depth_o is 0, skip_o is 0 and overflow_o is 0. Lane i maps to bit i of every lane vector.
- R2: An accepted branch strobe (br_if_i) sets active_o to the previous active_o AND cond_i from the next cycle, and increments depth_o by one.
- R3: An else strobe (br_else_i) at nonzero depth sets active_o to the mask from before the matching branch AND NOT the cond_i sampled at that branch. Lanes that were inactive before the branch stay inactive.
- R4: An endif strobe (br_endif_i) at nonzero depth restores active_o to the mask from before the matching branch and decrements depth_o by one.
- R5: Branches nest up to DEPTH (4) levels. Each else and endif refers to the innermost open level.
- R6: skip_o is 1 exactly when depth_o is nonzero and active_o is all zero, that is, when the current path has no active lane.
- R7: rf_we_o[i] equals wr_req_i AND active_o[i] in the same cycle. A disabled lane never has its write enable high.
- R8: A branch strobe at depth DEPTH sets overflow_o, which stays set until reset. active_o and depth_o are unchanged by that strobe.
- R9: An else or endif strobe at depth 0 has no effect on active_o or depth_o.
- R10: When several strobes are high in one cycle, only one is acted on, in the priority order branch, then else, then endif.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | LANES | Per-lane branch condition, sampled on br_if_i |
| br_if_i | input | 1 | Open a branch (taken path) |
| br_else_i | input | 1 | Switch to the alternative path |
| br_endif_i | input | 1 | Reconverge and close the branch |
| wr_req_i | input | 1 | Current instruction writes the register file |
| active_o | output | LANES | Per-lane execution mask |
| rf_we_o | output | LANES | Per-lane register-file write enable |
| skip_o | output | 1 | Current path has no active lane |
| depth_o | output | $clog2(DEPTH+1) | Number of open branch levels |
| overflow_o | output | 1 | Sticky: a branch was opened on a full stack |

## Verification
The properties assume that the decoder behaves sensibly. Else and endif strobes are expected only inside an open branch. The depth-zero property holds only while no overflowed branch has been closed by a stray endif. The stimulus mostly keeps strobes one-hot and steers their choice by the model's depth. It still injects a fraction of simultaneous strobes, strobes at depth 0 and branches on a full stack, so that the priority rule, the ignore rule and the sticky error are all exercised. The depth-zero property is not checked once overflow_o is set.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_IF, OP_ELSE, OP_ENDIF} br_op_e;
endpackage

// File: rtl/simt_mask_dec.sv
module simt_mask_dec
  import simt_mask_pkg::*;
(
  input  logic   if_i,
  input  logic   else_i,
  input  logic   endif_i,
  output br_op_e op_o
);
  // fixed priority: open, switch, close
  always_comb begin
    if (if_i)         op_o = OP_IF;
    else if (else_i)  op_o = OP_ELSE;
    else if (endif_i) op_o = OP_ENDIF;
    else              op_o = OP_NONE;
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [LANES-1:0]             push_par_i,
  input  logic [LANES-1:0]             push_alt_i,
  output logic [LANES-1:0]             top_par_o,
  output logic [LANES-1:0]             top_alt_o,
  output logic [$clog2(DEPTH+1)-1:0]   depth_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int DW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0] par_q [DEPTH];
  logic [LANES-1:0] alt_q [DEPTH];
  logic [DW-1:0]    sp_q;
  logic [AW-1:0]    wr_idx, top_idx;

  assign full_o  = (sp_q == DW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign depth_o = sp_q;
  assign wr_idx  = AW'(sp_q);
  assign top_idx = AW'(sp_q - 1'b1);
  assign top_par_o = empty_o ? '1 : par_q[top_idx];
  assign top_alt_o = empty_o ? '1 : alt_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sp_q <= '0;
    else if (push_i && !full_o)  sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o)  sp_q <= sp_q - 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        par_q[g] <= '0;
        alt_q[g] <= '0;
      end else if (push_i && !full_o && wr_idx == AW'(g)) begin
        par_q[g] <= push_par_i;
        alt_q[g] <= push_alt_i;
      end
    end
  end
endmodule

// File: rtl/simt_div_mask_unit.sv
module simt_div_mask_unit
  import simt_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LANES-1:0]           cond_i,
  input  logic                       br_if_i,
  input  logic                       br_else_i,
  input  logic                       br_endif_i,
  input  logic                       wr_req_i,
  output logic [LANES-1:0]           active_o,
  output logic [LANES-1:0]           rf_we_o,
  output logic                       skip_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o,
  output logic                       overflow_o
);
  br_op_e           op;
  logic [LANES-1:0] act_q, act_d, top_par, top_alt;
  logic             full, empty, do_push, do_pop, do_alt, ovf_q;

  simt_mask_dec u_dec (
    .if_i(br_if_i), .else_i(br_else_i), .endif_i(br_endif_i), .op_o(op)
  );

  assign do_push = (op == OP_IF) && !full;
  assign do_alt  = (op == OP_ELSE) && !empty;
  assign do_pop  = (op == OP_ENDIF) && !empty;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stk (
    .clk_i, .rst_ni,
    .push_i(do_push), .pop_i(do_pop),
    .push_par_i(act_q), .push_alt_i(act_q & ~cond_i),
    .top_par_o(top_par), .top_alt_o(top_alt),
    .depth_o, .full_o(full), .empty_o(empty)
  );

  always_comb begin
    act_d = act_q;
    if (do_push)     act_d = act_q & cond_i;
    else if (do_alt) act_d = top_alt;
    else if (do_pop) act_d = top_par;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '1;
      ovf_q <= 1'b0;
    end else begin
      act_q <= act_d;
      if (op == OP_IF && full) ovf_q <= 1'b1;
    end
  end

  // write suppression per lane; ALU may still compute
  for (genvar l = 0; l < LANES; l++) begin : g_we
    assign rf_we_o[l] = wr_req_i & act_q[l];
  end

  assign active_o   = act_q;
  assign skip_o     = !empty && (act_q == '0);
  assign overflow_o = ovf_q;
endmodule

// File: rtl/simt_div_mask_chk.sv
module simt_div_mask_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [LANES-1:0]           cond_i,
  input logic                       br_if_i,
  input logic                       br_else_i,
  input logic                       br_endif_i,
  input logic                       wr_req_i,
  input logic [LANES-1:0]           active_o,
  input logic [LANES-1:0]           rf_we_o,
  input logic                       skip_o,
  input logic [$clog2(DEPTH+1)-1:0] depth_o,
  input logic                       overflow_o
);
  localparam int DW = $clog2(DEPTH+1);

  a_r1_full_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == '0 && !overflow_o) |-> (active_o == '1));

  a_r2_taken_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_if_i && depth_o != DW'(DEPTH)) |=>
      (active_o == ($past(active_o) & $past(cond_i))));

  a_r4_pop_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_if_i && !br_else_i && br_endif_i && depth_o != '0) |=>
      (depth_o == $past(depth_o) - 1'b1));

  a_r6_skip_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (active_o == '0 && depth_o != '0));

  a_r7_we_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o & ~active_o) == '0);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r8_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_if_i && depth_o == DW'(DEPTH)) |=>
      ($stable(active_o) && $stable(depth_o) && overflow_o));

  a_r9_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_if_i && depth_o == '0) |=> (depth_o == '0 && $stable(active_o)));
endmodule

bind simt_div_mask_unit simt_div_mask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_simt_div_mask_unit.sv
module sim_simt_div_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int DEPTH = 4;
  localparam int DW = $clog2(DEPTH+1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LANES-1:0] cond = '0;
  logic             b_if = 0, b_else = 0, b_endif = 0, wr = 0;
  logic [LANES-1:0] act, we;
  logic             skip, ovf;
  logic [DW-1:0]    dep;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [LANES-1:0] m_act;
  logic [LANES-1:0] m_par [DEPTH];
  logic [LANES-1:0] m_alt [DEPTH];
  int               m_dep;
  bit               m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_div_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond),
    .br_if_i(b_if), .br_else_i(b_else), .br_endif_i(b_endif), .wr_req_i(wr),
    .active_o(act), .rf_we_o(we), .skip_o(skip), .depth_o(dep), .overflow_o(ovf)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [LANES-1:0] exp_we(input logic w, input logic [LANES-1:0] a);
    return w ? a : '0;
  endfunction

  task automatic model_reset();
    m_act = '1; m_dep = 0; m_ovf = 0;
  endtask

  // priority: if > else > endif
  task automatic model_step(input logic i, input logic e, input logic n, input logic [LANES-1:0] c);
    if (i) begin
      if (m_dep == DEPTH) m_ovf = 1;
      else begin
        m_par[m_dep] = m_act; m_alt[m_dep] = m_act & ~c;
        m_act = m_act & c; m_dep++;
      end
    end else if (e) begin
      if (m_dep != 0) m_act = m_alt[m_dep-1];
    end else if (n) begin
      if (m_dep != 0) begin m_act = m_par[m_dep-1]; m_dep--; end
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R2/R3/R4 active"}, 32'(act), 32'(m_act));
    chk({tag, " R5 depth"}, 32'(dep), 32'(m_dep));
    chk({tag, " R6 skip"}, 32'(skip), 32'(m_dep != 0 && m_act == '0));
    chk({tag, " R8 overflow"}, 32'(ovf), 32'(m_ovf));
  endtask

  // called at a negedge: drive, check comb write enable, clock, check state
  task automatic step(input string tag, input logic i, input logic e, input logic n,
                      input logic [LANES-1:0] c, input logic w);
    b_if = i; b_else = e; b_endif = n; cond = c; wr = w;
    #1;
    chk({tag, " R7 rf_we"}, 32'(we), 32'(exp_we(w, m_act)));
    @(posedge clk);
    model_step(i, e, n, c);
    @(negedge clk);
    b_if = 0; b_else = 0; b_endif = 0;
    check_state(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset active", 32'(act), 32'(8'hFF));
    chk("R1 reset depth", 32'(dep), 0);
    chk("R1 reset skip", 32'(skip), 0);
    chk("R1 reset ovf", 32'(ovf), 0);

    // R9: else/endif at depth 0 ignored
    step("R9 else@0", 0, 1, 0, 8'h00, 1);
    step("R9 endif@0", 0, 0, 1, 8'h0F, 0);
    // R2/R3/R4 basic diverge
    step("R2 if", 1, 0, 0, 8'hA5, 1);
    step("R3 else", 0, 1, 0, 8'h00, 1);
    step("R4 endif", 0, 0, 1, 8'h00, 1);
    // R6: no lane true -> taken path empty, else full
    step("R6 if none", 1, 0, 0, 8'h00, 1);
    step("R6 else all", 0, 1, 0, 8'h00, 1);
    step("R6 endif", 0, 0, 1, 8'h00, 0);
    // R6: all true -> else path empty
    step("R6 if all", 1, 0, 0, 8'hFF, 0);
    step("R6 else none", 0, 1, 0, 8'h00, 1);
    step("R6 endif2", 0, 0, 1, 8'h00, 1);
    // R5/R3: nested, inner else keeps outer-inactive lanes off
    step("R5 if1", 1, 0, 0, 8'hF0, 1);
    step("R5 if2", 1, 0, 0, 8'h3C, 1);
    step("R3 inner else", 0, 1, 0, 8'hFF, 1);
    step("R5 if3", 1, 0, 0, 8'h40, 1);
    step("R5 if4", 1, 0, 0, 8'hFF, 1);
    // R8: full stack
    step("R8 overflow", 1, 0, 0, 8'h00, 1);
    step("R8 sticky", 0, 0, 0, 8'h00, 1);
    // R10: simultaneous strobes
    step("R10 else+endif", 0, 1, 1, 8'h00, 1);
    step("R10 if+endif", 1, 1, 1, 8'h11, 1);
    repeat (4) step("R4 unwind", 0, 0, 1, 8'h00, 1);
    // reset clears sticky flag
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check_state("R1 re-reset");

    for (int k = 0; k < 2000; k++) begin
      int r;
      logic i, e, n;
      r = $urandom_range(0, 99);
      i = 0; e = 0; n = 0;
      if (r < 5)       begin i = 1; e = $urandom_range(0, 1); n = 1; end
      else if (r < 8)  n = 1;
      else if (m_dep == 0) i = (r < 70);
      else if (r < 40) i = 1;
      else if (r < 65) e = 1;
      else if (r < 90) n = 1;
      step("RND", i, e, n, LANES'($urandom()), 1'($urandom()));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule